// File: doc/BRIEF.md
# Memory-in-pixel LCD single-line write master

This block is a serial master that pushes one row of pixels into a monochrome memory-in-pixel display panel. The host presents a line address, a 144-bit pixel row and the frame-inversion bit, then pulses a start strobe. The block takes a copy of those inputs and raises an active-high chip select. It then clocks out a fixed 176-bit frame, made of three mode bits, five padding bits, the 8-bit gate address, the pixel row and sixteen trailing transfer clocks. Finally it lowers chip select and pulses done.

The serial clock comes from the system clock through a divider whose high and low halves both last `HALF_DIV` system clocks. Serial data is updated while the serial clock is low, and the panel samples it on the rising edge. Three programmable cycle counts set the timing around the clocking. The setup count sets how long chip select is high before the first serial clock. The hold count sets how long chip select stays high after the last serial clock. The gap count sets how long chip select stays low before another frame may begin.

Top module: `mlcd_line_tx`

## Requirements
- R1: While reset is asserted, and after it with no start, `lcd_cs_o`, `lcd_sck_o`, `lcd_mosi_o`, `busy_o` and `done_o` are all low.
- R2: A frame contains exactly 176 rising edges of `lcd_sck_o`. Sampled at those edges, `lcd_mosi_o` carries the following bits in order: 1, then `vcom_i`, then 0, then five 0 bits, then `line_addr_i[0]` up to `line_addr_i[7]`, then `pix_i[0]` up to `pix_i[143]`, then sixteen 0 bits.
- R3: `lcd_sck_o` is low whenever `lcd_cs_o` is low. `lcd_mosi_o` stays constant on every system clock in which `lcd_sck_o` is high, and it never changes in the same cycle that `lcd_sck_o` rises.
- R4: Every high phase of `lcd_sck_o` lasts exactly `HALF_DIV` system clocks. Every low phase between two serial clocks also lasts exactly `HALF_DIV` system clocks.
- R5: `lcd_cs_o` and `busy_o` rise one system clock after a start is accepted. The first rising edge of `lcd_sck_o` comes `SETUP_CYC + HALF_DIV` system clocks after `lcd_cs_o` rises.
- R6: After the last falling edge of `lcd_sck_o`, `lcd_cs_o` stays high for exactly `HOLD_CYC` system clocks.
- R7: `done_o` is high for exactly one system clock per frame, in the first cycle in which `lcd_cs_o` is low again. `busy_o` is high whenever `lcd_cs_o` is high, and it falls `GAP_CYC` system clocks after `lcd_cs_o` falls.
- R8: A start while `busy_o` is high is ignored. The frame in progress keeps its bits, and no extra frame follows.
- R9: If start is held high continuously, consecutive frames are separated by exactly `GAP_CYC + 1` system clocks with `lcd_cs_o` low.
- R10: Address, pixel row and inversion bit are captured on the accepted start. Changing them during the frame has no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one line; acted on only when idle |
| line_addr_i | input | ADDR_W | Gate line address, sent least significant bit first |
| vcom_i | input | 1 | Frame-inversion level placed in the second mode bit |
| pix_i | input | PIX_N | Pixel row; bit 0 is sent first |
| busy_o | output | 1 | Frame or post-frame gap in progress |
| done_o | output | 1 | One-cycle pulse when chip select returns low |
| lcd_cs_o | output | 1 | Panel chip select, active high |
| lcd_sck_o | output | 1 | Serial clock to the panel |
| lcd_mosi_o | output | 1 | Serial data to the panel |

## Verification
The embedded properties assume that reset is held long enough for every register to settle, and that the parameters pass the elaboration checks, which require every count to be at least one. They place no limit on how `start_i` behaves, so the bench is free to hold it high through whole frames, pulse it in the middle of a frame and hold it across frame boundaries. The bench changes inputs only on falling system-clock edges, so the design captures them at a single, known rising edge. The bench never changes the parameters during a run.

// File: rtl/mlcd_pkg.sv
`timescale 1ns/1ps
package mlcd_pkg;

   // Frame-level sequencing states of the line writer.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_SHIFT = 3'd2,
      ST_HOLD  = 3'd3,
      ST_GAP   = 3'd4
   } mlcd_state_e;

   // The mode field is three bits by panel definition: write, inversion, clear.
   localparam int MODE_BITS = 3;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/mlcd_clkdiv.sv
`timescale 1ns/1ps
module mlcd_clkdiv #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("mlcd_clkdiv: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_div_one
         // Every system clock closes a half period.
         assign tick_o = run_i;
      end else begin : g_div_cnt
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || cnt_q == CNT_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = run_i && (cnt_q == CNT_LAST);

         // R4: half-period ends are never back to back when the divider exceeds one
         p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o)
            else $error("p_tick_spaced_r4 violated");
      end
   endgenerate

endmodule

// File: rtl/mlcd_timer.sv
`timescale 1ns/1ps
module mlcd_timer #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("mlcd_timer: W must be at least 1");
      end
   endgenerate

   // Saturating up-counter; the sequencer clears it on every phase change.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (cnt_o != {W{1'b1}}) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/mlcd_bitsel.sv
`timescale 1ns/1ps
module mlcd_bitsel
   import mlcd_pkg::*;
#(
   parameter int PAD_N  = 5,
   parameter int ADDR_W = 8,
   parameter int PIX_N  = 144,
   parameter int TAIL_N = 16,
   localparam int TOTAL = MODE_BITS + PAD_N + ADDR_W + PIX_N + TAIL_N,
   localparam int IW    = $clog2(TOTAL)
) (
   input  logic [IW-1:0]     idx_i,
   input  logic              vcom_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PIX_N-1:0]  pix_i,
   output logic              bit_o
);

   generate
      if (PAD_N < 1 || TAIL_N < 1 || ADDR_W < 1 || PIX_N < 1) begin : g_bad_fields
         $error("mlcd_bitsel: every field length must be at least 1");
      end
   endgenerate

   // Whole frame laid out with bit 0 transmitted first. The mode field is
   // write=1, inversion=vcom, clear=0; padding and tail are driven low.
   logic [TOTAL-1:0] frame;

   assign frame = { {TAIL_N{1'b0}},
                    pix_i,
                    addr_i,
                    {PAD_N{1'b0}},
                    1'b0, vcom_i, 1'b1 };

   assign bit_o = frame[idx_i];

endmodule

// File: rtl/mlcd_line_tx.sv
`timescale 1ns/1ps
module mlcd_line_tx
   import mlcd_pkg::*;
#(
   parameter int HALF_DIV  = 2,
   parameter int SETUP_CYC = 3,
   parameter int HOLD_CYC  = 2,
   parameter int GAP_CYC   = 4,
   parameter int ADDR_W    = 8,
   parameter int PIX_N     = 144,
   parameter int PAD_N     = 5,
   parameter int TAIL_N    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] line_addr_i,
   input  logic              vcom_i,
   input  logic [PIX_N-1:0]  pix_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              lcd_cs_o,
   output logic              lcd_sck_o,
   output logic              lcd_mosi_o
);

   localparam int TOTAL = MODE_BITS + PAD_N + ADDR_W + PIX_N + TAIL_N;
   localparam int IW    = $clog2(TOTAL);
   localparam int TMAX  = max3(SETUP_CYC, HOLD_CYC, GAP_CYC);
   localparam int TW    = $clog2(TMAX + 1);

   localparam logic [IW-1:0] BIT_LAST  = IW'(TOTAL - 1);
   localparam logic [TW-1:0] LIM_SETUP = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] LIM_HOLD  = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] LIM_GAP   = TW'(GAP_CYC - 1);

   generate
      if (SETUP_CYC < 1 || HOLD_CYC < 1 || GAP_CYC < 1) begin : g_bad_delays
         $error("mlcd_line_tx: setup, hold and gap counts must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("mlcd_line_tx: HALF_DIV must be at least 1");
      end
   endgenerate

   mlcd_state_e        state_q, state_d;
   logic [IW-1:0]      bit_q;
   logic               ph_q;
   logic               done_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [PIX_N-1:0]   pix_q;
   logic               vcom_q;

   logic               half_tick;
   logic               fall_evt;
   logic               tmr_clr;
   logic [TW-1:0]      tmr_cnt;
   logic [TW-1:0]      tmr_lim;
   logic               tmr_exp;
   logic               sel_bit;

   // ---------------- serial clock divider ----------------
   mlcd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == ST_SHIFT),
      .tick_o (half_tick)
   );

   // A falling serial edge happens where a high half period closes.
   assign fall_evt = half_tick && ph_q;

   // ---------------- shared phase timer ----------------
   always_comb begin
      unique case (state_q)
         ST_SETUP: tmr_lim = LIM_SETUP;
         ST_HOLD:  tmr_lim = LIM_HOLD;
         default:  tmr_lim = LIM_GAP;
      endcase
   end

   assign tmr_exp = (tmr_cnt == tmr_lim);
   assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE) || (state_q == ST_SHIFT);

   mlcd_timer #(.W(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (tmr_clr),
      .cnt_o (tmr_cnt)
   );

   // ---------------- sequencer ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i)                          state_d = ST_SETUP;
         ST_SETUP: if (tmr_exp)                          state_d = ST_SHIFT;
         ST_SHIFT: if (fall_evt && bit_q == BIT_LAST)    state_d = ST_HOLD;
         ST_HOLD:  if (tmr_exp)                          state_d = ST_GAP;
         ST_GAP:   if (tmr_exp)                          state_d = ST_IDLE;
         default:                                        state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ph_q    <= 1'b0;
         bit_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_HOLD) && (state_d == ST_GAP);

         if (state_q != ST_SHIFT) begin
            ph_q <= 1'b0;
         end else if (half_tick) begin
            ph_q <= ~ph_q;
         end

         if (state_q == ST_IDLE) begin
            bit_q <= '0;
         end else if (state_q == ST_SHIFT && fall_evt && bit_q != BIT_LAST) begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   // Line contents are taken only when a frame is accepted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         pix_q  <= '0;
         vcom_q <= 1'b0;
      end else if (state_q == ST_IDLE && start_i) begin
         addr_q <= line_addr_i;
         pix_q  <= pix_i;
         vcom_q <= vcom_i;
      end
   end

   // ---------------- frame bit selection ----------------
   mlcd_bitsel #(
      .PAD_N  (PAD_N),
      .ADDR_W (ADDR_W),
      .PIX_N  (PIX_N),
      .TAIL_N (TAIL_N)
   ) u_sel (
      .idx_i  (bit_q),
      .vcom_i (vcom_q),
      .addr_i (addr_q),
      .pix_i  (pix_q),
      .bit_o  (sel_bit)
   );

   // ---------------- outputs ----------------
   assign lcd_cs_o   = (state_q == ST_SETUP) || (state_q == ST_SHIFT) || (state_q == ST_HOLD);
   assign lcd_sck_o  = (state_q == ST_SHIFT) && ph_q;
   assign lcd_mosi_o = (state_q == ST_SETUP || state_q == ST_SHIFT) ? sel_bit : 1'b0;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;

   // ---------------- assertions ----------------
   // R3: the serial clock rests low outside a frame
   p_sck_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_cs_o |-> !lcd_sck_o)
      else $error("p_sck_low_idle_r3 violated");

   // R3: data is already settled when the serial clock rises
   p_mosi_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_sck_o) |-> $stable(lcd_mosi_o))
      else $error("p_mosi_setup_r3 violated");

   // R3: data holds through the high half period
   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_sck_o && $past(lcd_sck_o)) |-> $stable(lcd_mosi_o))
      else $error("p_mosi_hold_r3 violated");

   // R7: done marks the return of chip select to low
   p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_cs_o) |-> done_o)
      else $error("p_done_at_release_r7 violated");

   // R7: done lasts a single cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("p_done_single_r7 violated");

   // R7: chip select high implies busy
   p_busy_covers_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_cs_o |-> busy_o)
      else $error("p_busy_covers_cs_r7 violated");

   // R8 / R10: a running frame keeps the line it accepted
   p_capture_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(pix_q) && $stable(addr_q) && $stable(vcom_q)))
      else $error("p_capture_frozen_r8 violated");

endmodule

// File: tb/mlcd_line_tx_bench.sv
`timescale 1ns/1ps
module mlcd_line_tx_bench;

   localparam int HD = 2;
   localparam int SU = 3;
   localparam int HO = 2;
   localparam int GP = 4;
   localparam int NB = 176;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         vcom = 1'b0;
   logic [7:0]   addr = '0;
   logic [143:0] pix = '0;
   logic         busy, done, cs, sck, mosi;

   always #2.5 clk = ~clk;

   mlcd_line_tx #(
      .HALF_DIV(HD), .SETUP_CYC(SU), .HOLD_CYC(HO), .GAP_CYC(GP),
      .ADDR_W(8), .PIX_N(144), .PAD_N(5), .TAIL_N(16)
   ) u_mlcd_line_tx (
      .clk(clk), .rst_n(rst_n), .start_i(start), .line_addr_i(addr),
      .vcom_i(vcom), .pix_i(pix), .busy_o(busy), .done_o(done),
      .lcd_cs_o(cs), .lcd_sck_o(sck), .lcd_mosi_o(mosi)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- monitor (samples away from the active edge) ----------------
   int cyc = 0, cs_rise = 0, cs_fall = 0, first_rise = -1, last_fall = 0;
   int nbits = 0, run_bad = 0, sdo_bad = 0, idle_bad = 0;
   int done_cnt = 0, done_cyc = 0, busy_fall = 0, busy_rise = 0, frames = 0, run = 0;
   logic [NB-1:0] cap = '0;
   logic p_cs = 1'b0, p_sck = 1'b0, p_mosi = 1'b0, p_busy = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (cs && !p_cs) begin cs_rise = cyc; nbits = 0; first_rise = -1; end
      if (!cs && p_cs) begin cs_fall = cyc; frames++; end
      if (busy && !p_busy) busy_rise = cyc;
      if (!busy && p_busy) busy_fall = cyc;
      if (sck && !cs) idle_bad++;
      if (sck && p_sck && mosi != p_mosi) sdo_bad++;
      if (sck && !p_sck) begin
         if (nbits < NB) cap[nbits] = mosi;
         if (first_rise < 0) first_rise = cyc;
         else if (run != HD) run_bad++;
         nbits++;
      end
      if (!sck && p_sck) begin
         last_fall = cyc;
         if (run != HD) run_bad++;
      end
      if (sck == p_sck) run++; else run = 1;
      if (done) begin done_cnt++; done_cyc = cyc; end
      p_cs = cs; p_sck = sck; p_mosi = mosi; p_busy = busy;
   end

   function automatic logic [NB-1:0] exp_frame(input logic [7:0] a, input logic v,
                                               input logic [143:0] p);
      logic [NB-1:0] f;
      f = '0;
      f[0] = 1'b1;
      f[1] = v;
      f[2] = 1'b0;
      for (int i = 0; i < 8; i++)   f[8 + i]  = a[i];
      for (int i = 0; i < 144; i++) f[16 + i] = p[i];
      return f;
   endfunction

   task automatic wait_idle();
      int n;
      n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic clear_mon();
      run_bad = 0; sdo_bad = 0; idle_bad = 0; done_cnt = 0;
   endtask

   task automatic check_bits(input logic [NB-1:0] ef, input string req);
      int first;
      first = -1;
      for (int i = NB - 1; i >= 0; i--) if (cap[i] !== ef[i]) first = i;
      chk(nbits == NB, req, "serial clock count", nbits, NB);
      chk(first < 0, req, "first mismatching frame bit index", first, -1);
   endtask

   task automatic check_timing();
      chk(first_rise - cs_rise == SU + HD, "R5", "cs rise to first sck rise", first_rise - cs_rise, SU + HD);
      chk(busy_rise == cs_rise, "R5", "busy rise vs cs rise", busy_rise, cs_rise);
      chk(cs_fall - last_fall == HO, "R6", "last sck fall to cs fall", cs_fall - last_fall, HO);
      chk(run_bad == 0, "R4", "half periods of wrong length", run_bad, 0);
      chk(sdo_bad == 0, "R3", "mosi changes while sck high", sdo_bad, 0);
      chk(idle_bad == 0, "R3", "sck high with cs low", idle_bad, 0);
      chk(done_cnt == 1, "R7", "done pulses per frame", done_cnt, 1);
      chk(done_cyc == cs_fall, "R7", "done cycle vs cs fall", done_cyc, cs_fall);
      chk(busy_fall - cs_fall == GP, "R7", "cs fall to busy fall", busy_fall - cs_fall, GP);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      chk({cs, sck, mosi, busy, done} == 5'b0, "R1", "outputs in reset", {cs, sck, mosi, busy, done}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({cs, sck, mosi, busy, done} == 5'b0, "R1", "outputs idle after reset", {cs, sck, mosi, busy, done}, 0);
   endtask

   task automatic t_frame(input logic [7:0] a, input logic v, input logic [143:0] p,
                          input string tag);
      clear_mon();
      @(negedge clk);
      addr = a; vcom = v; pix = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && cs, "R5", {tag, " busy and cs one cycle after start"}, {busy, cs}, 3);
      wait_idle();
      check_bits(exp_frame(a, v, p), "R2");
      check_timing();
   endtask

   task automatic t_busy_ignore();
      logic [143:0] p0;
      int f0;
      for (int i = 0; i < 144; i++) p0[i] = (i % 5 == 1);
      clear_mon();
      f0 = frames;
      @(negedge clk);
      addr = 8'h3C; vcom = 1'b1; pix = p0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      // new line and new starts while the frame runs
      addr = 8'hC3; vcom = 1'b0; pix = ~p0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      check_bits(exp_frame(8'h3C, 1'b1, p0), "R10");
      chk(done_cnt == 1, "R8", "done pulses with starts while busy", done_cnt, 1);
      repeat (30) @(negedge clk);
      chk(frames == f0 + 1, "R8", "frames after ignored starts", frames - f0, 1);
      chk(!cs && !busy, "R8", "no extra frame", {cs, busy}, 0);
   endtask

   task automatic t_back_to_back();
      logic [143:0] p1;
      int f0, n, gap;
      for (int i = 0; i < 144; i++) p1[i] = (i % 3 == 0);
      clear_mon();
      f0 = frames;
      @(negedge clk);
      addr = 8'h80; vcom = 1'b0; pix = p1; start = 1'b1;
      n = 0;
      while (!(frames == f0 + 1 && cs) && n < 5000) begin @(negedge clk); n++; end
      #1;
      gap = cs_rise - cs_fall;
      chk(gap == GP + 1, "R9", "cs low cycles between frames", gap, GP + 1);
      start = 1'b0;
      wait_idle();
      check_bits(exp_frame(8'h80, 1'b0, p1), "R9");
      chk(frames == f0 + 2, "R9", "frames with start held", frames - f0, 2);
   endtask

   initial begin
      logic [143:0] pa;
      for (int i = 0; i < 144; i++) pa[i] = i[0];
      t_reset_state();
      t_frame(8'h01, 1'b0, pa, "alternating row");
      t_frame(8'hA5, 1'b1, ~pa, "inverted row");
      t_frame(8'hFF, 1'b1, {144{1'b1}}, "all ones");
      t_frame(8'h00, 1'b0, 144'h0, "all zeros");
      t_busy_ignore();
      t_back_to_back();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule